// File: doc/BRIEF.md
# Priority Vector Interrupt Controller

This block gathers interrupt requests from up to eight peripheral sources into a register of pending flags. It drives one level-sensitive request line toward a processor. A source raises a request by pulsing its set strobe for one clock, and the flag stays set until it is serviced.

When the processor runs an acknowledge cycle, the block pulses the acknowledge input for one clock. The block then looks at the flags as they stood in that cycle and selects the highest-numbered pending source. It returns that source's fixed vector on a 16-bit word, asserts a valid flag for one cycle, and clears only that source's flag. The request line stays high until every pending flag has been serviced, so the processor can take further acknowledges one after another until the line drops.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A synchronous reset clears every pending flag. After the reset edge, `irq_o`, `vec_vld_o` and `vec_o` are all zero, and a following acknowledge returns no valid vector.
- R2: A set strobe on any source in cycle t makes `irq_o` high after the clock edge that ends cycle t.
- R3: An acknowledge selects the pending source with the highest index: source 7 has the top priority and source 0 the lowest.
- R4: The vector for source n is the octal value 0300 + 4*(7-n), so source 7 gives 0300 and source 0 gives 0334. Bits 15:8 of `vec_o` are zero.
- R5: An acknowledge clears only the flag of the source it selected. Later acknowledges return the remaining sources in descending index order.
- R6: `irq_o` stays high while any flag is pending, and falls after the edge of the acknowledge that clears the last one.
- R7: An acknowledge while no flag is pending leaves the flags unchanged, keeps `irq_o` low, and drives `vec_vld_o` low with `vec_o` at zero.
- R8: If a set strobe and an acknowledge that clears the same source fall in one cycle, the set wins and that source stays pending.
- R9: The vector comes from the flags sampled in the acknowledge cycle. A set strobe of a higher-priority source in that same cycle does not change the vector issued. That source is served by the next acknowledge.
- R10: `vec_vld_o` is high for exactly the one cycle after an acknowledge that found a pending flag, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | 8 | One-cycle set strobe per source, bit n for source n |
| iack_i | input | 1 | One-cycle acknowledge strobe from the processor |
| irq_o | output | 1 | Level request, high while any flag is pending |
| vec_o | output | 16 | Vector of the source served by the last acknowledge |
| vec_vld_o | output | 1 | High for one cycle when `vec_o` carries a new vector |

## Verification
The bench loads each of the 256 possible pending patterns and drains it with acknowledges. For every step it checks the vector against an arithmetic model, along with the request level. This separates priority order, vector encoding and single-bit clearing across every mix of sources. It then issues one more acknowledge on the empty register to check the no-vector case.

Three directed cases cover the remaining rules. A set and a clear of the same source in one cycle shows that the set wins. A higher-priority set during an acknowledge shows that the vector comes from the sampled flags. A reset with flags pending checks that everything is cleared.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // Vector for source idx: highest index gets the base, each lower source adds a step.
  function automatic int vec_of(input int idx, input int nsrc, input int base, input int step);
    return base + step * (nsrc - 1 - idx);
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o,
  output logic         any_o
);
  logic [N-1:0] mask_d;

  // set has priority over a clear of the same bit
  assign mask_d = (mask_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      any_o  <= 1'b0;
    end else begin
      mask_o <= mask_d;
      any_o  <= |mask_d;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] above;

  assign above[N] = 1'b0;

  genvar g;
  generate
    for (g = N - 1; g >= 0; g--) begin : g_chain
      assign above[g]    = above[g+1] | mask_i[g];
      assign onehot_o[g] = mask_i[g] & ~above[g+1];
    end
  endgenerate

  assign any_o = above[0];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out
  import irq_vec_pkg::*;
#(
  parameter int N        = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 192,
  parameter int VEC_STEP = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_i,
  input  logic             any_i,
  input  logic [IW-1:0]    idx_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vld_o
);
  logic [VEC_W-1:0] vec_d;

  assign vec_d = VEC_W'(vec_of(int'(idx_i), N, VEC_BASE, VEC_STEP));

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= ack_i & any_i;
      if (ack_i) vec_o <= any_i ? vec_d : '0;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N        = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 192,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src_set_i,
  input  logic             iack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  mask_q;
  logic [N-1:0]  top_1h;
  logic [N-1:0]  clr;
  logic [IW-1:0] top_idx;
  logic          top_any;

  assign clr = iack_i ? top_1h : '0;

  irq_pend_reg #(.N(N)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (src_set_i),
    .clr_i  (clr),
    .mask_o (mask_q),
    .any_o  (irq_o)
  );

  irq_prio_pick #(.N(N)) u_pick (
    .mask_i   (mask_q),
    .onehot_o (top_1h),
    .idx_o    (top_idx),
    .any_o    (top_any)
  );

  irq_vec_out #(
    .N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_out (
    .clk   (clk),
    .rst   (rst),
    .ack_i (iack_i),
    .any_i (top_any),
    .idx_i (top_idx),
    .vec_o (vec_o),
    .vld_o (vec_vld_o)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N        = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 192,
  parameter int VEC_STEP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     src_set_i,
  input logic             iack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_vld_o
);
  localparam int VMIN = VEC_BASE;
  localparam int VMAX = VEC_BASE + VEC_STEP * (N - 1);

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (!irq_o && !vec_vld_o && vec_o == '0));

  p_set_raises_r2: assert property (@(posedge clk) disable iff (rst) (|src_set_i) |=> irq_o);

  p_vec_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> (int'(vec_o) >= VMIN && int'(vec_o) <= VMAX && vec_o[1:0] == 2'b00));

  p_ack_serves_r5: assert property (@(posedge clk) disable iff (rst) (iack_i && irq_o) |=> vec_vld_o);

  p_level_holds_r6: assert property (@(posedge clk) disable iff (rst) (irq_o && !iack_i) |=> irq_o);

  p_empty_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (iack_i && !irq_o && !(|src_set_i)) |=> (!vec_vld_o && !irq_o));

  p_valid_after_ack_r10: assert property (@(posedge clk) disable iff (rst) vec_vld_o |-> $past(iack_i));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_set_i (src_set_i),
  .iack_i    (iack_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .vec_vld_o (vec_vld_o)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  src_set_i;
  logic        iack_i;
  logic        irq_o;
  logic [15:0] vec_o;
  logic        vec_vld_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .src_set_i(src_set_i), .iack_i(iack_i),
    .irq_o(irq_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  function automatic int exp_vec(input int idx);
    return 192 + 4 * (7 - idx);
  endfunction

  function automatic int top_bit(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  // advance one cycle: inputs already applied at negedge, sample at next negedge
  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; src_set_i = '0; iack_i = 1'b0;
    @(negedge clk); cyc();
    rst = 1'b0;
    chk("R1 irq after reset", irq_o, 0);
    chk("R1 vld after reset", vec_vld_o, 0);
    chk("R1 vec after reset", vec_o, 0);

    // Exhaustive sweep over all pending patterns
    for (int m = 0; m < 256; m++) begin
      logic [7:0] model;
      model = 8'(m);
      src_set_i = 8'(m); cyc();
      src_set_i = '0;
      chk("R2 irq after set", irq_o, (m != 0) ? 1 : 0);
      while (model != 0) begin
        int t;
        t = top_bit(model);
        iack_i = 1'b1; cyc();
        iack_i = 1'b0;
        chk("R10 vld after ack", vec_vld_o, 1);
        chk("R3 R4 vector of highest", vec_o, exp_vec(t));
        model[t] = 1'b0;
        chk("R5 R6 irq level after clear", irq_o, (model != 0) ? 1 : 0);
      end
      iack_i = 1'b1; cyc();
      iack_i = 1'b0;
      chk("R7 empty ack vld", vec_vld_o, 0);
      chk("R7 empty ack irq", irq_o, 0);
      cyc();
      chk("R10 vld idle", vec_vld_o, 0);
    end

    // R8: set and clear of same source in one cycle
    src_set_i = 8'h08; cyc();
    chk("R2 irq set bit3", irq_o, 1);
    iack_i = 1'b1; cyc();
    src_set_i = '0; iack_i = 1'b0;
    chk("R8 vector bit3", vec_o, exp_vec(3));
    chk("R8 irq stays", irq_o, 1);
    iack_i = 1'b1; cyc();
    iack_i = 1'b0;
    chk("R8 bit3 served again", vec_o, exp_vec(3));
    chk("R8 vld second", vec_vld_o, 1);
    chk("R6 irq drops", irq_o, 0);
    cyc();

    // R9: higher-priority set arrives in acknowledge cycle
    src_set_i = 8'h04; cyc();
    src_set_i = 8'h80; iack_i = 1'b1; cyc();
    src_set_i = '0; iack_i = 1'b0;
    chk("R9 sampled vector bit2", vec_o, exp_vec(2));
    chk("R9 irq still high", irq_o, 1);
    iack_i = 1'b1; cyc();
    iack_i = 1'b0;
    chk("R9 next vector bit7", vec_o, exp_vec(7));
    chk("R4 upper byte zero", vec_o[15:8], 0);
    chk("R6 irq low after last", irq_o, 0);
    cyc();

    // R1: reset with pending flags
    src_set_i = 8'h61; cyc();
    src_set_i = '0;
    iack_i = 1'b1; cyc();
    iack_i = 1'b0;
    chk("R3 bit6 first", vec_o, exp_vec(6));
    rst = 1'b1; cyc();
    rst = 1'b0;
    chk("R1 irq cleared", irq_o, 0);
    chk("R1 vld cleared", vec_vld_o, 0);
    chk("R1 vec cleared", vec_o, 0);
    iack_i = 1'b1; cyc();
    iack_i = 1'b0;
    chk("R1 no vector after reset", vec_vld_o, 0);
    chk("R7 vec zero on empty ack", vec_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule